// File: doc/BRIEF.md
# Bit-Serial CRC-32 Frame Engine

This block computes the 32-bit Ethernet-style cyclic redundancy check of a short serial frame one bit per clock, while the frame is being shifted onto or off the wire. No copy of the frame is kept. A 32-bit feedback shift register is the only storage for the checksum. Every frame carries its own length, from 12 to 64 bits, which is known before the frame begins. A start pulse loads that length into a bit budget and presets the register. The engine then takes exactly that many valid bits and raises a one-cycle done strobe with the finished check value.

In generate mode the output is the inverted register, bit-reversed so that `crc_out[0]` is the first check bit to transmit. In verify mode the engine also takes the 32 received check bits after the payload. It then flags whether the register has reached the fixed residue that every error-free frame leaves behind. A start pulse at any point abandons the current frame and begins a new one.

Top module: `serial_frame_crc`

## Requirements
- R1: After reset, `done` and `crc_ok` are 0 and `crc_out` is 0x00000000.
- R2: `crc_out` equals the reflected CRC-32 of the consumed bits, taken in arrival order. The model presets 0xFFFFFFFF. For each bit b it computes f = reg[0]^b, shifts the register right one place, and XORs in 0xEDB88320 when f is 1. The result is the complement of the register. This is the same as the MSB-first polynomial 0x04C11DB7.
- R3: `crc_out[0]` is the check bit to send first, and `crc_out[31]` is the last.
- R4: `done` is high for exactly one cycle. That cycle is the one after the clock edge that consumes the last bit of the frame. `done` is never high during the frame.
- R5: A cycle with `bit_valid` low does not consume a bit and does not change the result.
- R6: The frame lengths 12 and 64 both work, as does any length in between.
- R7: When `check_mode` is 1 at start, the engine consumes `frame_len`+32 bits. `crc_ok` is 1 in the done cycle only if the register then holds the residue 0xC704DD7B, in MSB-first form. Otherwise it is 0. `crc_ok` is never 1 outside a done cycle.
- R8: A `start` pulse during a frame abandons that frame and presets the register. Any bit presented in the start cycle is not consumed.
- R9: Valid bits presented while no frame is active are ignored, and `crc_out` keeps its value.
- R10: `frame_len` and `check_mode` are sampled only in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new frame (presets the register, loads the bit budget) |
| check_mode | input | 1 | 1 = verify a received frame that includes its check bits |
| frame_len | input | 7 | Payload length in bits (12..64) |
| bit_valid | input | 1 | `bit_in` holds a frame bit this cycle |
| bit_in | input | 1 | Serial frame bit |
| done | output | 1 | One-cycle strobe after the last bit |
| crc_out | output | 32 | Check value, bit 0 sent first |
| crc_ok | output | 1 | Verify result, valid with `done` |

## Verification
Random payloads of random length with random idle gaps are checked against a bench model of the reflected CRC. Gaps that were counted as bits, or a wrong tap set, both give a value that differs from the model. Directed frames at lengths 12 and 64 test the ends of the bit budget. Verify runs use a correct frame and then the same frame with one bit flipped. This shows that the residue compare responds to the data and is not tied high. Abort, idle-bit and mid-frame length-change cases show whether state leaks across a start pulse, or whether the engine accepts input it should ignore.

// File: rtl/serial_crc_pkg.sv
// Package: constants shared by the serial CRC-32 engine.
// Assumes an MSB-first register form of the Ethernet polynomial.
package serial_crc_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;
endpackage

// File: rtl/crc_shift_reg.sv
// Module: crc_shift_reg
// A W-bit shift register with XOR feedback taps. It advances by one message
// bit on each `step` and returns to the seed on `init`.
// Assumes: init has priority over step. The register is never read before
// the first init, because reset also seeds it.
module crc_shift_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] state
);
    logic         feedback;
    logic [W-1:0] next_state;

    // Feedback is the outgoing top bit XOR the incoming message bit.
    always_comb begin
        feedback   = state[W-1] ^ din;
        next_state = {state[W-2:0], 1'b0} ^ (feedback ? POLY : '0);
    end

    // Register update: seed on reset or init, shift on step.
    always_ff @(posedge clk) begin
        if (!rst_n)     state <= SEED;
        else if (init)  state <= SEED;
        else if (step)  state <= next_state;
    end

    // R8
    preset_on_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (state == SEED));
    // R5
    hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !step) |=> $stable(state));
endmodule

// File: rtl/bit_budget_counter.sv
// Module: bit_budget_counter
// Counts down the number of bits left in a frame. It marks the frame active
// while bits remain, and pulses `done` one cycle after the final bit.
// Assumes: load may arrive at any time and restarts the count. A load value
// of zero leaves the counter idle.
module bit_budget_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             consume,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] remaining;
    logic             last_bit;

    // The final bit of the frame is consumed in this cycle.
    assign last_bit = busy && consume && !load && (remaining == CNT_W'(1));

    // Budget and activity: load restarts, each consumed bit decrements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            busy      <= 1'b0;
        end else if (load) begin
            remaining <= load_val;
            busy      <= (load_val != '0);
        end else if (busy && consume) begin
            remaining <= remaining - CNT_W'(1);
            if (remaining == CNT_W'(1)) busy <= 1'b0;
        end
    end

    // Completion strobe, registered one cycle after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last_bit;
    end

    // R4
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && consume && !load && remaining == CNT_W'(1)) |=> (done && !busy));
    // R9
    idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> (!busy && $stable(remaining)));
endmodule

// File: rtl/serial_frame_crc.sv
// Module: serial_frame_crc (top)
// Bit-serial CRC-32 over frames of a known length, processed while the bits
// stream in. Generate mode reports the inverted, bit-reversed register.
// Verify mode also consumes the 32 received check bits and compares the
// register with the fixed residue.
// Assumes: frame_len lies in 12..64 and is valid in the start cycle.
module serial_frame_crc
    import serial_crc_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             check_mode,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic             done,
    output logic [CRC_W-1:0] crc_out,
    output logic             crc_ok
);
    localparam int CNT_W = LEN_W + 1;

    logic             busy;
    logic             step;
    logic             verify_q;
    logic [CNT_W-1:0] budget;
    logic [CRC_W-1:0] crc_state;

    // Bit budget for this frame: the payload, plus the check field when verifying.
    assign budget = CNT_W'(frame_len) + (check_mode ? CNT_W'(CRC_W) : '0);

    // A bit is consumed only inside a frame, and never in a start cycle.
    assign step = busy && bit_valid && !start;

    // Mode capture: check_mode is sampled only when a frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n)     verify_q <= 1'b0;
        else if (start) verify_q <= check_mode;
    end

    crc_shift_reg #(.W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start),
        .step  (step),
        .din   (bit_in),
        .state (crc_state)
    );

    bit_budget_counter #(.CNT_W(CNT_W)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (budget),
        .consume  (bit_valid),
        .busy     (busy),
        .done     (done)
    );

    // Output order: invert and reverse, so bit 0 is the first bit on the wire.
    for (genvar i = 0; i < CRC_W; i++) begin : g_reflect
        assign crc_out[i] = ~crc_state[CRC_W-1-i];
    end

    // Verify result, presented only together with the done strobe.
    assign crc_ok = done && verify_q && (crc_state == CRC_RESIDUE);

    // R7
    ok_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> done);
    // R9
    idle_output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc_out));
endmodule

// File: tb/sim_serial_frame_crc.sv
module sim_serial_frame_crc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        check_mode = 1'b0;
    logic [6:0]  frame_len = '0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        done;
    logic [31:0] crc_out;
    logic        crc_ok;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    serial_frame_crc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .check_mode(check_mode),
        .frame_len(frame_len), .bit_valid(bit_valid), .bit_in(bit_in),
        .done(done), .crc_out(crc_out), .crc_ok(crc_ok)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Reflected CRC-32 model, bits[i] is the i-th bit sent.
    function automatic logic [31:0] crc_ref(input logic [95:0] bits, input int n);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            logic f = r[0] ^ bits[i];
            r = r >> 1;
            if (f) r = r ^ 32'hEDB88320;
        end
        return ~r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic begin_frame(input int len, input bit mode);
        start = 1'b1; frame_len = 7'(len); check_mode = mode;
        bit_valid = 1'b1; bit_in = 1'b1;       // R8: bit in the start cycle ignored
        @(negedge clk);
        start = 1'b0; bit_valid = 1'b0;
    endtask

    // Sends n bits with random gaps. It checks done stays low mid-frame and,
    // unless open_end is set, checks done rises after the last bit.
    task automatic send_bits(input logic [95:0] bits, input int n, input int gap_pct,
                             input bit open_end);
        for (int i = 0; i < n; i++) begin
            while (($urandom % 100) < gap_pct) begin
                bit_valid = 1'b0; bit_in = 1'($urandom);
                @(negedge clk);
                check(done == 1'b0, "R5 done low in gap", 32'(done), 32'd0);
            end
            bit_valid = 1'b1; bit_in = bits[i];
            @(negedge clk);
            if (i != n-1 || open_end)
                check(done == 1'b0, "R4 done low mid-frame", 32'(done), 32'd0);
        end
        bit_valid = 1'b0;
    endtask

    task automatic gen_frame(input logic [95:0] bits, input int len, input int gap_pct,
                             input string req);
        logic [31:0] exp = crc_ref(bits, len);
        begin_frame(len, 1'b0);
        send_bits(bits, len, gap_pct, 1'b0);
        check(done == 1'b1, {req, " done after last bit"}, 32'(done), 32'd1);
        check(crc_out == exp, {req, " crc value"}, crc_out, exp);
        check(crc_ok == 1'b0, "R7 crc_ok low in generate mode", 32'(crc_ok), 32'd0);
        @(negedge clk);
        check(done == 1'b0, "R4 done single cycle", 32'(done), 32'd0);
    endtask

    task automatic verify_frame(input logic [63:0] data, input int len,
                                input int flip, input bit exp_ok);
        logic [95:0] bits = 96'(data);
        logic [31:0] c = crc_ref(bits, len);
        for (int k = 0; k < 32; k++) bits[len+k] = c[k];   // R3: bit 0 first
        if (flip >= 0) bits[flip] = ~bits[flip];
        begin_frame(len, 1'b1);
        send_bits(bits, len + 32, 10, 1'b0);
        check(done == 1'b1, "R7 done after len+32 bits", 32'(done), 32'd1);
        check(crc_ok == exp_ok, "R7 residue compare", 32'(crc_ok), 32'(exp_ok));
        @(negedge clk);
        check(crc_ok == 1'b0, "R7 crc_ok only with done", 32'(crc_ok), 32'd0);
    endtask

    initial begin
        logic [95:0] b;
        logic [31:0] held;
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
        check(crc_ok == 1'b0, "R1 reset crc_ok", 32'(crc_ok), 32'd0);
        check(crc_out == 32'h0, "R1 reset crc_out", crc_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: a fixed pattern. An all-zero 32-bit payload gives 0x2144DF1C here.
        gen_frame(96'h0, 32, 0, "R3 zero word");
        // R6: shortest and longest frames
        gen_frame(96'({$urandom, $urandom}), 12, 0, "R6 len12");
        gen_frame(96'({$urandom, $urandom}), 64, 0, "R6 len64");
        gen_frame(96'h0, 12, 0, "R6 len12 zeros");
        gen_frame(96'({32'hFFFF_FFFF, 32'hFFFF_FFFF}), 64, 20, "R6 len64 ones");
        // R2/R5: random lengths, data and gaps
        for (int t = 0; t < 40; t++)
            gen_frame(96'({$urandom, $urandom}), 12 + int'($urandom % 53),
                      int'($urandom % 40), "R2 random");

        // R7: good frames pass, one flipped bit fails
        verify_frame({$urandom, $urandom}, 12, -1, 1'b1);
        verify_frame({$urandom, $urandom}, 64, -1, 1'b1);
        verify_frame({$urandom, $urandom}, 40, 7, 1'b0);
        verify_frame({$urandom, $urandom}, 40, 60, 1'b0);

        // R8: abort mid-frame, then a full new frame
        begin_frame(50, 1'b0);
        send_bits(96'({$urandom, $urandom}), 9, 0, 1'b1);
        gen_frame(96'h0000_0000_0000_0A5C, 16, 0, "R8 after abort");

        // R10: frame_len and check_mode changed mid-frame are not used
        b = 96'({$urandom, $urandom});
        begin_frame(20, 1'b0);
        frame_len = 7'd60; check_mode = 1'b1;
        send_bits(b, 20, 0, 1'b0);
        check(done == 1'b1, "R10 done at sampled length", 32'(done), 32'd1);
        check(crc_out == crc_ref(b, 20), "R10 crc", crc_out, crc_ref(b, 20));
        check(crc_ok == 1'b0, "R10 mode sampled at start", 32'(crc_ok), 32'd0);
        held = crc_out;
        @(negedge clk);

        // R9: valid bits while idle change nothing
        for (int i = 0; i < 6; i++) begin
            bit_valid = 1'b1; bit_in = 1'($urandom);
            @(negedge clk);
            check(done == 1'b0, "R9 no done when idle", 32'(done), 32'd0);
            check(crc_out == held, "R9 crc_out held", crc_out, held);
        end
        bit_valid = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule